// File: doc/BRIEF.md
# Shadow-Read Control Register File

This block holds a set of 32-bit device control registers as individual flip-flops whose outputs drive the devices in parallel. A simple synchronous bus writes them by word address. Every accepted write lands in two places: the addressed flip-flop register and one location of a synchronous RAM that covers the whole address window.

Reads never pass through a wide multiplexer over all registers. They are answered from the RAM copy, so a read returns the last value the bus wrote, not a value the device may have produced. A device can raise its own override bit to make a read of its register return a shared live data word instead. The final read path is a small select between the RAM output, the live word and zero.

The window is `2**WIN_BITS` words (512 by default) starting at an aligned `BASE`. The first `NUM_REGS` offsets have flip-flop registers. The remaining offsets are RAM-only storage.

Top module: `shadow_regfile`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_rvalid` is 0, `bus_rdata` is 0 and every register output is 0.
- R2: A write to window offset k with k < NUM_REGS updates register output k at the first rising edge after the request. No other register output changes.
- R3: `bus_rvalid` is high in exactly those cycles that follow a cycle with `bus_re` high. A read therefore completes one clock after the request.
- R4: A read of an in-window address returns the last value written there. This also holds for offsets that have no flip-flop register.
- R5: A read issued in the same cycle as a write to that address returns the new data. So does a read in the following cycle.
- R6: When the read targets register k and `ovr_req[k]` is high in the request cycle, the result is `live_data` as sampled in that request cycle.
- R7: Override bits of registers other than the one being read have no effect. The shadow value is returned.
- R8: Writes outside the window (upper address bits above WIN_BITS differing from BASE) change no register output and no shadow location.
- R9: A read outside the window completes normally with `bus_rdata` equal to 0.
- R10: `bus_rdata` is 0 in every cycle where `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Word address of the request |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read result, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read result strobe, one cycle after `bus_re` |
| reg_q | output | NUM_REGS*DATA_W (512) | Register outputs; register k at bits k*32 upward |
| ovr_req | input | NUM_REGS (16) | Per-register request to read the live word |
| live_data | input | DATA_W (32) | Live value supplied by an overriding device |

## Verification
Register outputs and read results are both due one rising edge after the request cycle. The bench drives each request at a falling edge and samples at the next falling edge. That sampling point lies after exactly one register stage of either path.

Each table row checks the strobe and data produced by the previous row before it drives its own request. A read that shares a cycle with a write, or directly follows one, is checked against the new value. Override rows sample `live_data` in the request cycle only, so the result is checked against the word driven with the request.

// File: rtl/shadow_regfile_pkg.sv
package shadow_regfile_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Read-side state carried alongside the RAM access cycle.
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              use_live;
        logic [DATA_W-1:0] live;
    } rd_stage_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int unsigned win_bits);
        return (a >> win_bits) == (base >> win_bits);
    endfunction

endpackage

// File: rtl/srf_addr_decode.sv
module srf_addr_decode
    import shadow_regfile_pkg::*;
#(
    parameter int              WIN_BITS = 9,
    parameter int              NUM_REGS = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h1000
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [WIN_BITS-1:0] offset,
    output logic [NUM_REGS-1:0] reg_sel
);

    assign hit    = in_window(addr, BASE, WIN_BITS);
    assign offset = addr[WIN_BITS-1:0];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
        assign reg_sel[k] = hit && (offset == WIN_BITS'(k));
    end

    always_comb begin
        assert ($onehot0(reg_sel)) else $error("AST_SEL_ONEHOT"); // R2
    end

endmodule

// File: rtl/srf_reg_bank.sv
module srf_reg_bank
    import shadow_regfile_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [NUM_REGS-1:0]          sel,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NUM_REGS*DATA_W-1:0]   q
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                q[k*DATA_W +: DATA_W] <= '0;
            else if (wr_en && sel[k])
                q[k*DATA_W +: DATA_W] <= wdata;
        end

        AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && sel[k]) |=> $stable(q[k*DATA_W +: DATA_W])); // R2
    end

endmodule

// File: rtl/srf_shadow_ram.sv
module srf_shadow_ram
    import shadow_regfile_pkg::*;
#(
    parameter int WIN_BITS = 9,
    localparam int DEPTH   = 1 << WIN_BITS
) (
    input  logic                clk,
    input  logic                we,
    input  logic                re,
    input  logic [WIN_BITS-1:0] addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write-first: a same-cycle write to the read address forwards its data.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata <= we ? wdata : mem[addr];
    end

    AST_WRITE_FIRST: assert property (@(posedge clk)
        (we && re) |=> rdata == $past(wdata)); // R5

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
    import shadow_regfile_pkg::*;
#(
    parameter int                WIN_BITS = 9,
    parameter int                NUM_REGS = 16,
    parameter logic [ADDR_W-1:0] BASE     = 16'h1000,
    localparam int               REGS_W   = NUM_REGS * DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic                bus_re,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic [REGS_W-1:0]   reg_q,
    input  logic [NUM_REGS-1:0] ovr_req,
    input  logic [DATA_W-1:0]   live_data
);

    bus_req_t            req;
    rd_stage_t           rd_q;
    logic                hit;
    logic [WIN_BITS-1:0] offset;
    logic [NUM_REGS-1:0] reg_sel;
    logic [DATA_W-1:0]   ram_q;
    logic                wr_hit;
    logic                rd_hit;

    assign req    = '{we: bus_we, re: bus_re, addr: bus_addr, wdata: bus_wdata};
    assign wr_hit = req.we && hit;
    assign rd_hit = req.re && hit;

    srf_addr_decode #(
        .WIN_BITS (WIN_BITS),
        .NUM_REGS (NUM_REGS),
        .BASE     (BASE)
    ) u_dec (
        .addr    (req.addr),
        .hit     (hit),
        .offset  (offset),
        .reg_sel (reg_sel)
    );

    srf_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_hit),
        .sel   (reg_sel),
        .wdata (req.wdata),
        .q     (reg_q)
    );

    srf_shadow_ram #(
        .WIN_BITS (WIN_BITS)
    ) u_shadow (
        .clk   (clk),
        .we    (wr_hit),
        .re    (rd_hit),
        .addr  (offset),
        .wdata (req.wdata),
        .rdata (ram_q)
    );

    // Override and live word are captured with the request so they line up with the RAM output.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q.valid    <= req.re;
            rd_q.hit      <= hit;
            rd_q.use_live <= |(reg_sel & ovr_req);
            rd_q.live     <= live_data;
        end
    end

    always_comb begin
        if (!rd_q.valid || !rd_q.hit)
            bus_rdata = '0;
        else if (rd_q.use_live)
            bus_rdata = rd_q.live;
        else
            bus_rdata = ram_q;
    end
    assign bus_rvalid = rd_q.valid;

    AST_RVALID_AFTER_RE: assert property (@(posedge clk) disable iff (rst)
        bus_re |=> bus_rvalid); // R3
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> !bus_rvalid); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rvalid |-> bus_rdata == '0); // R10
    AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && !hit) |=> bus_rdata == '0); // R9
    AST_OUTSIDE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !hit) |=> $stable(reg_q)); // R8
    AST_OVERRIDE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (bus_re && |(reg_sel & ovr_req)) |=> bus_rdata == $past(live_data)); // R6

endmodule

// File: tb/shadow_regfile_test.sv
`timescale 1ns/1ps
module shadow_regfile_test;

    localparam int DW = 32;
    localparam int NR = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [15:0]   bus_addr;
    logic          bus_we;
    logic          bus_re;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;
    logic [NR*DW-1:0] reg_q;
    logic [NR-1:0] ovr_req;
    logic [DW-1:0] live_data;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk; // 250 MHz

    shadow_regfile uut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .reg_q      (reg_q),
        .ovr_req    (ovr_req),
        .live_data  (live_data)
    );

    typedef struct packed {
        logic        we;
        logic        re;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [15:0] ovr;
        logic [31:0] live;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 16'h1003, 32'hA5A50003, 16'h0000, 32'h0,        32'h0,        8'd2}, // R2 write reg 3
        '{1'b1, 1'b0, 16'h1005, 32'h00001111, 16'h0000, 32'h0,        32'h0,        8'd2}, // R2 write reg 5
        '{1'b0, 1'b1, 16'h1003, 32'h0,        16'h0000, 32'h0,        32'hA5A50003, 8'd4}, // R4 shadow read
        '{1'b1, 1'b0, 16'h1100, 32'hCAFEF00D, 16'h0000, 32'h0,        32'h0,        8'd4}, // R4 RAM-only offset
        '{1'b0, 1'b1, 16'h1100, 32'h0,        16'h0000, 32'h0,        32'hCAFEF00D, 8'd4}, // R4
        '{1'b1, 1'b1, 16'h1005, 32'h12345678, 16'h0000, 32'h0,        32'h12345678, 8'd5}, // R5 same cycle
        '{1'b0, 1'b1, 16'h1005, 32'h0,        16'h0000, 32'h0,        32'h12345678, 8'd5}, // R5 next cycle
        '{1'b0, 1'b1, 16'h1003, 32'h0,        16'h0008, 32'hDEADBEEF, 32'hDEADBEEF, 8'd6}, // R6 override reg 3
        '{1'b0, 1'b1, 16'h1003, 32'h0,        16'h0020, 32'h0BADF00D, 32'hA5A50003, 8'd7}, // R7 other bit
        '{1'b1, 1'b0, 16'h0003, 32'hFFFFFFFF, 16'h0000, 32'h0,        32'h0,        8'd8}, // R8 outside write
        '{1'b0, 1'b1, 16'h0003, 32'h0,        16'h0000, 32'h0,        32'h0,        8'd9}, // R9 outside read
        '{1'b0, 1'b1, 16'h1003, 32'h0,        16'h0000, 32'h0,        32'hA5A50003, 8'd8}, // R8 shadow intact
        '{1'b0, 1'b0, 16'h1003, 32'h0,        16'hFFFF, 32'h55555555, 32'h0,        8'd10} // R10 idle
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic re, input logic [15:0] a,
                         input logic [31:0] wd, input logic [15:0] ov, input logic [31:0] lv);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = wd; ovr_req = ov; live_data = lv;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b1, 16'h1003, 32'h0, '0, 32'h0);
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk(bus_rvalid == 1'b0, "R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
        chk(bus_rdata == '0, "R1 rdata", bus_rdata, 32'h0);
        chk(reg_q == '0, "R1 regs", reg_q[31:0], 32'h0);
        drive(1'b0, 1'b0, 16'h0, 32'h0, '0, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_rvalid == 1'b0, "R1 rvalid after release", {31'b0, bus_rvalid}, 32'h0);

        // Table walk: each row checks the previous row's result, then drives its own request.
        for (int i = 0; i <= NV; i++) begin
            if (i > 0) begin
                chk(bus_rvalid == VEC[i-1].re, "R3 rvalid", {31'b0, bus_rvalid}, {31'b0, VEC[i-1].re});
                if (VEC[i-1].re)
                    chk(bus_rdata == VEC[i-1].exp, $sformatf("R%0d rdata row %0d", VEC[i-1].req, i-1),
                        bus_rdata, VEC[i-1].exp);
                else
                    chk(bus_rdata == '0, "R10 idle rdata", bus_rdata, 32'h0);
            end
            if (i < NV)
                drive(VEC[i].we, VEC[i].re, VEC[i].addr, VEC[i].wdata, VEC[i].ovr, VEC[i].live);
            else
                drive(1'b0, 1'b0, 16'h0, 32'h0, '0, 32'h0);
            @(negedge clk);
        end

        // R2 and R8: register outputs after the table
        for (int k = 0; k < NR; k++) begin
            logic [31:0] e;
            e = (k == 3) ? 32'hA5A50003 : (k == 5) ? 32'h12345678 : 32'h0;
            chk(reg_q[k*DW +: DW] == e, $sformatf("R2 reg %0d", k), reg_q[k*DW +: DW], e);
        end

        // R2: register 15 updates one edge after the request, neighbours hold
        drive(1'b1, 1'b0, 16'h100F, 32'h0F0F0F0F, '0, 32'h0);
        @(negedge clk);
        drive(1'b0, 1'b0, 16'h0, 32'h0, '0, 32'h0);
        chk(reg_q[15*DW +: DW] == 32'h0F0F0F0F, "R2 reg 15 timing", reg_q[15*DW +: DW], 32'h0F0F0F0F);
        chk(reg_q[14*DW +: DW] == 32'h0, "R2 reg 14 hold", reg_q[14*DW +: DW], 32'h0);

        // R9: outside read aliasing a register offset with another upper page
        drive(1'b0, 1'b1, 16'h2003, 32'h0, 16'h0008, 32'h77777777);
        @(negedge clk);
        drive(1'b0, 1'b0, 16'h0, 32'h0, '0, 32'h0);
        chk(bus_rvalid == 1'b1, "R9 rvalid", {31'b0, bus_rvalid}, 32'h1);
        chk(bus_rdata == '0, "R9 rdata", bus_rdata, 32'h0);

        // R1: reset again clears the registers and the read strobe
        rst = 1'b1;
        drive(1'b0, 1'b1, 16'h1003, 32'h0, '0, 32'h0);
        @(negedge clk);
        chk(reg_q == '0, "R1 regs cleared", reg_q[15*DW +: DW], 32'h0);
        chk(bus_rvalid == 1'b0, "R1 rvalid in reset", {31'b0, bus_rvalid}, 32'h0);
        rst = 1'b0;
        drive(1'b0, 1'b0, 16'h0, 32'h0, '0, 32'h0);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule